// File: doc/BRIEF.md
# Receive Frame Queue with Word Readout

This block sits behind an Ethernet receive path and holds whole received frames until software fetches them. Frames arrive as a byte stream with first-byte and last-byte markers. Each accepted frame becomes one record in a ring of fixed-size slots. A record is a 16-bit little-endian length prefix, then the frame bytes, then a CRC-32 over the frame. The block computes the CRC byte by byte as the frame streams in.

Software drains the queue through a small register window. It reads a single data register over and over, and each read hands back the next four record bytes. Once the last word of a record has been read, the read side moves on to the next slot by itself. A register holds the number of complete records not yet read. The control register holds the receive-enable bit and a flush action bit. A one-cycle event pulse goes to the interrupt unit for each frame the queue accepts.

`SLOT_BYTES` sets the slot size. A deployment would use 2048. The default is smaller so that the default elaboration stays small.

Top module: `rxq_word_drain`

## Requirements
- R1: The queue holds up to `SLOTS` (default 31) complete records, and the pending count never exceeds `SLOTS`.
- R2: A frame is discarded whole when, at its first byte, receive is disabled (control bit 0 clear) or `SLOTS` records are already pending.
- R3: A record's bytes are, in order: the length n+6 as two bytes, low byte first (n is the frame size), then the n frame bytes, then the frame's CRC-32 (reflected polynomial 0xEDB88320, preset all ones, result inverted), low byte first.
- R4: Bytes of a record's last word that lie beyond the record's end read as zero.
- R5: Each read of the data register (offset 0x10) returns the next four record bytes, the earliest byte in bits 7:0. The first read of a record takes its length from the record's own prefix.
- R6: When the remaining length of the record being read falls to zero or below, the pending count drops by one. The next read then starts the following slot, and the slot index wraps from `SLOTS`-1 to 0, so records come out in arrival order.
- R7: Offset 0x34 reads the pending count. Offset 0x08 reads back the receive-enable bit in bit 0. No other readable bits are defined.
- R8: A data read while no record is pending and none is partly read returns zero and changes no state.
- R9: A write to offset 0x08 with bit 4 set clears the pending count and any partly read record, and aborts a frame that is still being stored. The next record stored is read from its start.
- R10: Each accepted frame produces exactly one single-cycle `rx_event` pulse. It comes in the fifth cycle after the cycle in which the last frame byte is taken, and the pending count includes the frame from the next cycle. A frame whose first byte arrives before that pulse has ended is discarded whole.
- R11: A frame longer than `SLOT_BYTES`-6 bytes is discarded whole. A frame of exactly that size is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| rx_event | output | 1 | One-cycle pulse per accepted frame |

## Verification
A stale read index or a miscounted remaining length shows up on the very next data read. It returns bytes from the wrong slot or the wrong offset, or it starts the next record too early, and the bench compares every word against its own model of the slots. A wrong pending count shows at offset 0x34 or as a queue that refuses or accepts one frame too many. A CRC or zero-fill fault shows in the tail word of the record concerned. A timing slip in the commit shifts `rx_event` by a cycle, and the bench checks that output on every clock while frames stream.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  localparam logic [5:0] ADDR_CTRL = 6'h08;
  localparam logic [5:0] ADDR_DATA = 6'h10;
  localparam logic [5:0] ADDR_PEND = 6'h34;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 4;

  localparam int TAIL_STEPS = 4;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_RECV,
    WS_SKIP,
    WS_TAIL
  } wstate_e;

  function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] din);
    logic [31:0] r;
    r = cur ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxq_slot_mem.sv
module rxq_slot_mem #(
  parameter int IDXW  = 5,
  parameter int WOFFW = 6
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic                  wr_half,
  input  logic [IDXW+WOFFW-1:0] waddr,
  input  logic [1:0]            wlane,
  input  logic [7:0]            wbyte,
  input  logic [15:0]           whalf,
  input  logic [IDXW+WOFFW-1:0] raddr,
  output logic [31:0]           rdata
);
  localparam int AW    = IDXW + WOFFW;
  localparam int DEPTH = 1 << AW;

  logic [31:0] store [DEPTH];

  // Lane 0 writes clear the upper lanes: this is what zero-fills a record's tail word.
  always_ff @(posedge clk) begin
    if (we) begin
      if (wr_half) begin
        store[waddr][15:0] <= whalf;
      end else if (wlane == 2'd0) begin
        store[waddr] <= {24'h0, wbyte};
      end else begin
        store[waddr][8*wlane +: 8] <= wbyte;
      end
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/rxq_frame_writer.sv
module rxq_frame_writer
  import rxq_pkg::*;
#(
  parameter int SLOT_BYTES = 256,
  parameter int IDXW       = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [7:0]              in_data,
  input  logic                    rx_en,
  input  logic                    q_full,
  input  logic                    flush,
  input  logic [IDXW-1:0]         wr_slot,
  output logic                    mem_we,
  output logic                    mem_half,
  output logic [IDXW+BOFFW-3:0]   mem_waddr,
  output logic [1:0]              mem_lane,
  output logic [7:0]              mem_byte,
  output logic [15:0]             mem_hword,
  output logic                    commit
);
  localparam int BOFFW     = $clog2(SLOT_BYTES);
  localparam int CNTW      = BOFFW + 1;
  localparam int MAX_FRAME = SLOT_BYTES - 6;

  wstate_e          state_q, state_d;
  logic [IDXW-1:0]  slot_q, slot_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [31:0]      crc_q, crc_d;
  logic [2:0]       step_q, step_d;
  logic [CNTW-1:0]  boff;
  logic [31:0]      fcs;
  logic [IDXW-1:0]  tgt_slot;

  assign fcs      = ~crc_q;
  assign tgt_slot = (state_q == WS_IDLE) ? wr_slot : slot_q;

  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    cnt_d    = cnt_q;
    crc_d    = crc_q;
    step_d   = step_q;
    mem_we   = 1'b0;
    mem_half = 1'b0;
    boff     = '0;
    mem_byte = in_data;
    commit   = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (in_valid && in_sof) begin
          if (!rx_en || q_full) begin
            state_d = in_eof ? WS_IDLE : WS_SKIP;
          end else begin
            slot_d  = wr_slot;
            mem_we  = 1'b1;
            boff    = CNTW'(2);
            cnt_d   = CNTW'(1);
            crc_d   = crc_step(32'hFFFF_FFFF, in_data);
            step_d  = '0;
            state_d = in_eof ? WS_TAIL : WS_RECV;
          end
        end
      end
      WS_RECV: begin
        if (in_valid) begin
          if (cnt_q == CNTW'(MAX_FRAME)) begin
            state_d = in_eof ? WS_IDLE : WS_SKIP;
          end else begin
            mem_we = 1'b1;
            boff   = cnt_q + CNTW'(2);
            cnt_d  = cnt_q + CNTW'(1);
            crc_d  = crc_step(crc_q, in_data);
            if (in_eof) state_d = WS_TAIL;
          end
        end
      end
      WS_SKIP: begin
        if (in_valid && in_eof) state_d = WS_IDLE;
      end
      WS_TAIL: begin
        mem_we = 1'b1;
        if (step_q == 3'(TAIL_STEPS)) begin
          mem_half = 1'b1;
          boff     = '0;
          commit   = 1'b1;
          state_d  = WS_IDLE;
        end else begin
          boff     = cnt_q + CNTW'(2) + CNTW'(step_q);
          mem_byte = fcs[8*step_q[1:0] +: 8];
          step_d   = step_q + 3'd1;
        end
      end
      default: state_d = WS_IDLE;
    endcase
    if (flush) begin
      state_d = WS_IDLE;
      commit  = 1'b0;
    end
  end

  assign mem_waddr = {tgt_slot, boff[BOFFW-1:2]};
  assign mem_lane  = boff[1:0];
  assign mem_hword = 16'(cnt_q) + 16'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      crc_q   <= 32'hFFFF_FFFF;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      crc_q   <= crc_d;
      step_q  <= step_d;
    end
  end

  AST_WRITE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (boff < CNTW'(SLOT_BYTES))); // R11
  AST_TAIL_LEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_TAIL) |-> (cnt_q != '0 && cnt_q <= CNTW'(MAX_FRAME))); // R11
  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !q_full); // R2
  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R10

endmodule

// File: rtl/rxq_word_reader.sv
module rxq_word_reader #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256,
  parameter int IDXW       = 5,
  parameter int PW         = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_pop,
  input  logic                       flush,
  input  logic                       commit,
  input  logic [31:0]                mem_rdata,
  output logic [IDXW+BOFFW-3:0]      mem_raddr,
  output logic [31:0]                data_word,
  output logic [PW-1:0]              pending,
  output logic [IDXW-1:0]            wr_slot,
  output logic                       q_full
);
  localparam int BOFFW = $clog2(SLOT_BYTES);
  localparam int WOFFW = BOFFW - 2;
  localparam int CNTW  = BOFFW + 1;
  localparam int SW    = IDXW + 1;

  logic [IDXW-1:0]  idx_q, idx_d;
  logic [PW-1:0]    pend_q, pend_d;
  logic [CNTW-1:0]  rem_q, rem_d;
  logic [WOFFW-1:0] off_q, off_d;

  logic             active, has_rec, pop, last;
  logic [WOFFW-1:0] cur_off;
  logic [CNTW-1:0]  eff;
  logic [IDXW-1:0]  idx_next;
  logic [SW-1:0]    sum;

  assign active    = (rem_q != '0);
  assign has_rec   = active || (pend_q != '0);
  assign cur_off   = active ? off_q : '0;
  assign mem_raddr = {idx_q, cur_off};
  assign eff       = active ? rem_q : mem_rdata[CNTW-1:0];
  assign last      = (eff <= CNTW'(4));
  assign pop       = rd_pop && has_rec;
  assign idx_next  = (idx_q == IDXW'(SLOTS - 1)) ? '0 : idx_q + IDXW'(1);
  assign sum       = SW'(idx_q) + SW'(pend_q);
  assign wr_slot   = (sum >= SW'(SLOTS)) ? IDXW'(sum - SW'(SLOTS)) : IDXW'(sum);
  assign q_full    = (pend_q == PW'(SLOTS));
  assign pending   = pend_q;
  assign data_word = has_rec ? mem_rdata : 32'h0;

  always_comb begin
    idx_d = idx_q;
    rem_d = rem_q;
    off_d = off_q;
    if (pop) begin
      if (last) begin
        rem_d = '0;
        off_d = '0;
        idx_d = idx_next;
      end else begin
        rem_d = eff - CNTW'(4);
        off_d = cur_off + WOFFW'(1);
      end
    end
    pend_d = pend_q + PW'(commit) - PW'(pop && last);
    if (flush) begin
      pend_d = '0;
      rem_d  = '0;
      off_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pend_q <= '0;
      rem_q  <= '0;
      off_q  <= '0;
    end else begin
      idx_q  <= idx_d;
      pend_q <= pend_d;
      rem_q  <= rem_d;
      off_q  <= off_d;
    end
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(SLOTS)); // R1
  AST_PARTIAL_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pend_q != '0)); // R6
  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !has_rec && !flush && !commit) |=> (pend_q == '0 && rem_q == '0 && $stable(idx_q))); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_q == '0 && rem_q == '0)); // R9
  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && last && !commit && !flush) |=> (pend_q == $past(pend_q) - PW'(1))); // R6

endmodule

// File: rtl/rxq_word_drain.sv
module rxq_word_drain
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rx_event
);
  localparam int IDXW  = $clog2(SLOTS);
  localparam int PW    = $clog2(SLOTS + 1);
  localparam int BOFFW = $clog2(SLOT_BYTES);
  localparam int WOFFW = BOFFW - 2;
  localparam int AW    = IDXW + WOFFW;

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  logic            rx_en_q;
  logic            ctrl_wr, flush, rd_pop;
  logic            mem_we, mem_half, commit, q_full;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [1:0]      mem_lane;
  logic [7:0]      mem_byte;
  logic [15:0]     mem_hword;
  logic [31:0]     mem_rdata, data_word;
  logic [PW-1:0]   pending;
  logic [IDXW-1:0] wr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign flush   = ctrl_wr && reg_wdata[CTRL_FLUSH_BIT];
  assign rd_pop  = reg_rd && (reg_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rx_en_q <= 1'b0;
    else if (ctrl_wr) rx_en_q <= reg_wdata[CTRL_EN_BIT];
  end

  rxq_frame_writer #(.SLOT_BYTES(SLOT_BYTES), .IDXW(IDXW)) u_writer (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .rx_en(rx_en_q), .q_full(q_full), .flush(flush), .wr_slot(wr_slot),
    .mem_we(mem_we), .mem_half(mem_half), .mem_waddr(mem_waddr), .mem_lane(mem_lane),
    .mem_byte(mem_byte), .mem_hword(mem_hword), .commit(commit)
  );

  rxq_slot_mem #(.IDXW(IDXW), .WOFFW(WOFFW)) u_mem (
    .clk(clk), .we(mem_we), .wr_half(mem_half), .waddr(mem_waddr), .wlane(mem_lane),
    .wbyte(mem_byte), .whalf(mem_hword), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  rxq_word_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .IDXW(IDXW), .PW(PW)) u_reader (
    .clk(clk), .rst_n(rst_core_n), .rd_pop(rd_pop), .flush(flush), .commit(commit),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .data_word(data_word),
    .pending(pending), .wr_slot(wr_slot), .q_full(q_full)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata[CTRL_EN_BIT] = rx_en_q;
      ADDR_DATA: reg_rdata = data_word;
      ADDR_PEND: reg_rdata = 32'(pending);
      default:   reg_rdata = '0;
    endcase
  end

  assign rx_event = commit;

  AST_EVENT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_event |-> (pending < PW'(SLOTS))); // R1
  AST_DISABLED_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!rx_en_q && $past(!rx_en_q) && !rx_event) |=> $stable(pending) || (pending == '0)); // R2

endmodule

// File: tb/rxq_word_drain_bench.sv
module rxq_word_drain_bench;
  localparam int CLK_P      = 10;
  localparam int SLOTS      = 31;
  localparam int SLOT_BYTES = 256;
  localparam int MAXF       = SLOT_BYTES - 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_event;

  rxq_word_drain #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rxq_word_drain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_event(rx_event)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Behavioural model: slot ring of byte arrays
  logic [7:0] mrec [SLOTS][SLOT_BYTES];
  int mlen [SLOTS];
  int m_head = 0, m_cnt = 0, m_rem = 0, m_off = 0;
  bit m_en = 0;
  int ev_edge = -10, ready_edge = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + i * i) & 255);
  endfunction

  function automatic logic [31:0] ref_crc(input int len, input int seed);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, fbyte(seed, i)};
      for (int j = 0; j < 8; j++) c = (c >> 1) ^ (c[0] ? 32'hEDB88320 : 32'h0);
    end
    return ~c;
  endfunction

  task automatic send_frame(input int len, input int seed, input int gap);
    bit acc;
    int slot, tot;
    logic [31:0] c;
    @(negedge clk);
    acc  = m_en && (m_cnt < SLOTS) && (cyc + 1 >= ready_edge) && (len <= MAXF);
    slot = (m_head + m_cnt) % SLOTS;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      chk("R10 event idle", {31'h0, rx_event}, {31'h0, cyc == ev_edge});
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = fbyte(seed, i);
    end
    if (acc) begin
      tot = len + 6;
      c = ref_crc(len, seed);
      mrec[slot][0] = 8'(tot & 255);
      mrec[slot][1] = 8'(tot >> 8);
      for (int i = 0; i < len; i++) mrec[slot][2 + i] = fbyte(seed, i);
      for (int k = 0; k < 4; k++) mrec[slot][2 + len + k] = c[8*k +: 8];
      mlen[slot] = tot;
      m_cnt++;
      ev_edge    = cyc + 1 + 4;
      ready_edge = cyc + 1 + 6;
    end
    for (int k = 1; k <= gap; k++) begin
      @(negedge clk);
      if (k == 1) begin in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; end
      chk("R10 event timing", {31'h0, rx_event}, {31'h0, cyc == ev_edge});
    end
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    m_en = v[0];
    if (v[4]) begin m_cnt = 0; m_rem = 0; m_off = 0; end
  endtask

  task automatic read_data(input string req);
    logic [31:0] exp, got;
    exp = '0;
    if (!(m_rem == 0 && m_cnt == 0)) begin
      if (m_rem == 0) begin m_rem = mlen[m_head]; m_off = 0; end
      for (int b = 0; b < 4; b++)
        exp[8*b +: 8] = (m_off + b < mlen[m_head]) ? mrec[m_head][m_off + b] : 8'h00;
      m_off += 4; m_rem -= 4;
      if (m_rem <= 0) begin m_rem = 0; m_head = (m_head + 1) % SLOTS; m_cnt--; end
    end
    reg_read(6'h10, got);
    chk(req, got, exp);
  endtask

  task automatic check_pending(input string req);
    logic [31:0] got;
    reg_read(6'h34, got);
    chk(req, got, 32'(m_cnt));
  endtask

  task automatic drain_all(input string req);
    while (m_cnt > 0) read_data(req);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R10 reset event", {31'h0, rx_event}, 32'h0);
    reg_read(6'h08, v); chk("R7 reset ctrl", v, 32'h0);
    check_pending("R7 reset pending");
    read_data("R8 empty read zero");
    check_pending("R8 empty read no change");

    // Disabled receive drops
    send_frame(12, 1, 8);
    check_pending("R2 disabled drop");

    reg_write(6'h08, 32'h1);
    reg_read(6'h08, v); chk("R7 enable readback", v, 32'h1);

    // Small and odd lengths: header, CRC, zero-fill, byte order
    send_frame(1, 3, 8);
    send_frame(2, 4, 8);
    send_frame(3, 5, 8);
    send_frame(4, 6, 8);
    send_frame(5, 7, 8);
    send_frame(60, 8, 8);
    check_pending("R7 pending six");
    read_data("R5 first word with prefix");
    drain_all("R3 R4 record contents");
    check_pending("R6 drained");

    // Fill to capacity, overflow drop, ring wrap
    for (int i = 0; i < SLOTS; i++) send_frame(10 + i, 20 + i, 7);
    check_pending("R1 full");
    send_frame(9, 99, 8);
    check_pending("R2 full drop");
    drain_all("R6 wrap order");
    check_pending("R6 empty after wrap");
    read_data("R8 empty after drain");

    // Size limit
    send_frame(MAXF + 1, 50, 8);
    check_pending("R11 oversize dropped");
    send_frame(MAXF, 51, 8);
    check_pending("R11 max size kept");
    drain_all("R11 max record");

    // Flush with a partly read record
    send_frame(20, 60, 8);
    send_frame(21, 61, 8);
    read_data("R5 partial one");
    read_data("R5 partial two");
    reg_write(6'h08, 32'h11);
    check_pending("R9 flush clears count");
    read_data("R9 read after flush zero");
    send_frame(9, 62, 8);
    drain_all("R9 fresh record after flush");

    // Frame starting inside the commit tail is lost
    send_frame(8, 70, 2);
    send_frame(8, 71, 8);
    check_pending("R10 close frame dropped");
    drain_all("R10 surviving record");

    // Disable again
    reg_write(6'h08, 32'h0);
    send_frame(15, 80, 8);
    check_pending("R2 disabled after use");
    read_data("R8 final empty read");

    done = 1;
    summary();
  end

endmodule